// File: doc/BRIEF.md
# Break Condition Comparator

This block is one hardware debug break channel. It watches every bus cycle that the processor issues. It compares the access address, after a per-bit mask, against a programmed break address. It can also compare one of four data buses against a programmed break data value. When a valid bus cycle meets the whole programmed condition, the block raises a one-cycle break request on the next clock.

Software programs the channel through a small register port. There are four registers: break address, address mask, break data, and a three-bit control register. The control register chooses which data bus takes part in the match. When one of the two 16-bit memory buses is chosen, that bus is compared against only one half of the break data register, and the other half of the register is ignored.

Top module: `brk_cmp`

## Requirements
- R1: After reset, all four registers read as zero and `brk_o` is low.
- R2: Register index 0 holds the break address, 1 the address mask, 2 the break data and 3 the control register. A read returns the last value written to that index. Control bits 31:3 always read as zero.
- R3: A mask bit of 0 makes the matching address bit take part in the comparison. A mask bit of 1 excludes that address bit. The address matches when `(cyc_addr_i ^ break_address) & ~mask` is zero.
- R4: With control bits 1:0 = 00, no data condition applies, and a matching address alone causes a break.
- R5: With control bits 1:0 = 01, all 32 bits of `ibus_i` must equal the break data register.
- R6: With control bits 1:0 = 10, all 32 bits of `sbus_i` must equal the break data register.
- R7: With control bits 1:0 = 11 and control bit 2 = 0, `xbus_i` must equal break data bits 31:16. Break data bits 15:0 have no effect.
- R8: With control bits 1:0 = 11 and control bit 2 = 1, `ybus_i` must equal break data bits 15:0. Break data bits 31:16 have no effect.
- R9: `brk_o` is high for exactly the one clock that follows a cycle with `cyc_valid_i` high and the full condition met. It is never high after a cycle with `cyc_valid_i` low. Back-to-back matching cycles give back-to-back pulses.
- R10: A register write takes effect in the cycle after the write. A bus cycle in the same clock as the write is judged against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the register selected by `reg_addr_i` |
| cyc_valid_i | input | 1 | A bus cycle is present this clock |
| cyc_addr_i | input | 32 | Address of the bus cycle |
| ibus_i | input | 32 | Internal 32-bit data bus |
| sbus_i | input | 32 | Second 32-bit data bus |
| xbus_i | input | 16 | X-memory 16-bit data bus |
| ybus_i | input | 16 | Y-memory 16-bit data bus |
| brk_o | output | 1 | Registered break request pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 32-bit data register, so the two memory buses are 16 bits wide. At this width the two halves of the break data register are separate, and the bench can load one half with a value that does not match while the other half matches. It does this to show that the unselected half has no effect. The 32-bit mask also lets the bench exclude a whole byte of the address, and to test a single address bit outside that byte as a miss.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned CTRL_W = 3;

  localparam logic [REG_AW-1:0] IDX_BAR  = 2'd0;
  localparam logic [REG_AW-1:0] IDX_MASK = 2'd1;
  localparam logic [REG_AW-1:0] IDX_BDR  = 2'd2;
  localparam logic [REG_AW-1:0] IDX_CTRL = 2'd3;

  typedef enum logic [1:0] {
    DSEL_NONE = 2'b00,
    DSEL_IBUS = 2'b01,
    DSEL_SBUS = 2'b10,
    DSEL_XY   = 2'b11
  } dsel_e;

  typedef struct packed {
    logic  xy_sel;  // 0: X lane (upper half), 1: Y lane (lower half)
    dsel_e dsel;
  } ctrl_t;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] idx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [AW-1:0]     bar_o,
  output logic [AW-1:0]     mask_o,
  output logic [DW-1:0]     bdr_o,
  output ctrl_t             ctrl_o
);
  logic [AW-1:0] bar_q, mask_q;
  logic [DW-1:0] bdr_q;
  ctrl_t         ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bar_q  <= '0;
      mask_q <= '0;
      bdr_q  <= '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      unique case (idx_i)
        IDX_BAR:  bar_q  <= wdata_i[AW-1:0];
        IDX_MASK: mask_q <= wdata_i[AW-1:0];
        IDX_BDR:  bdr_q  <= wdata_i;
        default:  ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      endcase
    end
  end

  always_comb begin
    unique case (idx_i)
      IDX_BAR:  rdata_o = DW'(bar_q);
      IDX_MASK: rdata_o = DW'(mask_q);
      IDX_BDR:  rdata_o = bdr_q;
      default:  rdata_o = DW'(ctrl_q);
    endcase
  end

  assign bar_o  = bar_q;
  assign mask_o = mask_q;
  assign bdr_o  = bdr_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] bar_i,
  input  logic [AW-1:0] mask_i,
  output logic          hit_o
);
  logic [AW-1:0] diff;

  for (genvar b = 0; b < AW; b++) begin : g_bit
    assign diff[b] = (addr_i[b] ^ bar_i[b]) & ~mask_i[b];
  end

  assign hit_o = ~|diff;
endmodule

// File: rtl/brk_data_cmp.sv
module brk_data_cmp
  import brk_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned HW = DW / 2
) (
  input  ctrl_t         ctrl_i,
  input  logic [DW-1:0] bdr_i,
  input  logic [DW-1:0] ibus_i,
  input  logic [DW-1:0] sbus_i,
  input  logic [HW-1:0] xbus_i,
  input  logic [HW-1:0] ybus_i,
  output logic          hit_o
);
  logic [1:0] lane_hit;  // [1]: X vs upper half, [0]: Y vs lower half

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [HW-1:0] src;
    assign src         = (l == 1) ? xbus_i : ybus_i;
    assign lane_hit[l] = (src == bdr_i[l*HW +: HW]);
  end

  always_comb begin
    unique case (ctrl_i.dsel)
      DSEL_NONE: hit_o = 1'b1;
      DSEL_IBUS: hit_o = (ibus_i == bdr_i);
      DSEL_SBUS: hit_o = (sbus_i == bdr_i);
      default:   hit_o = ctrl_i.xy_sel ? lane_hit[0] : lane_hit[1];
    endcase
  end
endmodule

// File: rtl/brk_cmp.sv
module brk_cmp
  import brk_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  localparam int unsigned HW = DW / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              cyc_valid_i,
  input  logic [AW-1:0]     cyc_addr_i,
  input  logic [DW-1:0]     ibus_i,
  input  logic [DW-1:0]     sbus_i,
  input  logic [HW-1:0]     xbus_i,
  input  logic [HW-1:0]     ybus_i,
  output logic              brk_o
);
  logic [AW-1:0] bar_q, mask_q;
  logic [DW-1:0] bdr_q;
  ctrl_t         ctrl_q;
  logic          addr_hit, data_hit, brk_q;

  brk_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .idx_i   (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .bar_o   (bar_q),
    .mask_o  (mask_q),
    .bdr_o   (bdr_q),
    .ctrl_o  (ctrl_q)
  );

  brk_addr_cmp #(.AW(AW)) u_addr (
    .addr_i (cyc_addr_i),
    .bar_i  (bar_q),
    .mask_i (mask_q),
    .hit_o  (addr_hit)
  );

  brk_data_cmp #(.DW(DW)) u_data (
    .ctrl_i (ctrl_q),
    .bdr_i  (bdr_q),
    .ibus_i (ibus_i),
    .sbus_i (sbus_i),
    .xbus_i (xbus_i),
    .ybus_i (ybus_i),
    .hit_o  (data_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brk_q <= 1'b0;
    else         brk_q <= cyc_valid_i & addr_hit & data_hit;
  end

  assign brk_o = brk_q;
endmodule

// File: rtl/brk_cmp_chk.sv
module brk_cmp_chk
  import brk_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [DW-1:0]     reg_wdata_i,
  input logic [DW-1:0]     reg_rdata_o,
  input logic              cyc_valid_i,
  input logic [AW-1:0]     cyc_addr_i,
  input logic              brk_o,
  input logic [AW-1:0]     bar_q,
  input logic [AW-1:0]     mask_q,
  input logic [CTRL_W-1:0] ctrl_q
);
  AST_NO_BRK_WO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cyc_valid_i) |-> !brk_o); // R9

  AST_ADDR_MISS_NO_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && ((cyc_addr_i ^ bar_q) & ~mask_q) != '0) |=> !brk_o); // R3

  AST_FULL_MASK_NO_DATA_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && (&mask_q) && ctrl_q[1:0] == 2'b00) |=> brk_o); // R4

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == IDX_CTRL) |-> (reg_rdata_o[DW-1:CTRL_W] == '0)); // R2

  AST_BAR_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == IDX_BAR) |=> (bar_q == $past(reg_wdata_i[AW-1:0]))); // R10
endmodule

bind brk_cmp brk_cmp_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .cyc_valid_i (cyc_valid_i),
  .cyc_addr_i  (cyc_addr_i),
  .brk_o       (brk_o),
  .bar_q       (bar_q),
  .mask_q      (mask_q),
  .ctrl_q      (ctrl_q)
);

// File: tb/tb_brk_cmp.sv
module tb_brk_cmp;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  ra = 2'd0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        vld = 1'b0;
  logic [31:0] ca = '0, ib = '0, sb = '0;
  logic [15:0] xb = '0, yb = '0;
  logic        brk;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_cmp dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(ra), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .cyc_valid_i(vld), .cyc_addr_i(ca),
    .ibus_i(ib), .sbus_i(sb), .xbus_i(xb), .ybus_i(yb),
    .brk_o(brk)
  );

  // reference model
  logic [31:0] m_bar, m_mask, m_bdr;
  logic [2:0]  m_ctrl;
  logic        m_brk;

  function automatic bit m_data_ok();
    case (m_ctrl[1:0])
      2'b00: return 1'b1;
      2'b01: return ib == m_bdr;
      2'b10: return sb == m_bdr;
      default: return m_ctrl[2] ? (yb == m_bdr[15:0]) : (xb == m_bdr[31:16]);
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] idx);
    case (idx)
      2'd0: return m_bar;
      2'd1: return m_mask;
      2'd2: return m_bdr;
      default: return {29'd0, m_ctrl};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bar <= '0; m_mask <= '0; m_bdr <= '0; m_ctrl <= '0; m_brk <= 1'b0;
    end else begin
      m_brk <= vld && (((ca ^ m_bar) & ~m_mask) == 32'd0) && m_data_ok();
      if (we) begin
        case (ra)
          2'd0: m_bar <= wd;
          2'd1: m_mask <= wd;
          2'd2: m_bdr <= wd;
          default: m_ctrl <= wd[2:0];
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    check(brk === m_brk, cur_req, "brk_o", {31'd0, brk}, {31'd0, m_brk});
    check(rdata === m_read(ra), (cur_req == "R1") ? "R1" : "R2", "reg_rdata_o", rdata, m_read(ra));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    we = 1'b1; ra = idx; wd = d;
    tick();
    we = 1'b0;
  endtask

  task automatic cyc(input logic [31:0] a, input logic [31:0] i, input logic [31:0] s,
                     input logic [15:0] x, input logic [15:0] y);
    vld = 1'b1; ca = a; ib = i; sb = s; xb = x; yb = y;
    tick();
    vld = 1'b0;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    cur_req = "R1";
    for (int k = 0; k < 4; k++) begin
      ra = k[1:0];
      #1;
      check(rdata === 32'd0, "R1", "reset read", rdata, 32'd0);
    end
    check(brk === 1'b0, "R1", "reset brk", {31'd0, brk}, 32'd0);
    tick();

    // R2: readback, ctrl upper bits zero
    cur_req = "R2";
    wr(2'd0, 32'hCAFE_F00D); ra = 2'd0; #1;
    check(rdata === 32'hCAFE_F00D, "R2", "bar read", rdata, 32'hCAFE_F00D);
    wr(2'd3, 32'hFFFF_FFFF); ra = 2'd3; #1;
    check(rdata === 32'h7, "R2", "ctrl read", rdata, 32'h7);
    wr(2'd3, 32'h0);

    // R3: masked address
    cur_req = "R3";
    wr(2'd0, 32'h1234_5678);
    wr(2'd1, 32'h0000_00FF);
    cyc(32'h1234_5600, 0, 0, 0, 0);
    cyc(32'h1234_5699, 0, 0, 0, 0);
    cyc(32'h1235_5678, 0, 0, 0, 0);
    cyc(32'h1234_5778, 0, 0, 0, 0);

    // R4: no data condition
    cur_req = "R4";
    cyc(32'h1234_5678, 32'h1111_1111, 32'h2222_2222, 16'h3333, 16'h4444);
    wr(2'd1, 32'hFFFF_FFFF);
    cyc(32'h0BAD_0BAD, 32'h5, 32'h6, 16'h7, 16'h8);
    wr(2'd1, 32'h0000_00FF);

    // R5: internal bus
    cur_req = "R5";
    wr(2'd2, 32'hDEAD_BEEF);
    wr(2'd3, 32'h1);
    cyc(32'h1234_5678, 32'hDEAD_BEEF, 32'h0, 16'h0, 16'h0);
    cyc(32'h1234_5678, 32'hDEAD_BEEE, 32'hDEAD_BEEF, 16'h0, 16'h0);

    // R6: second bus
    cur_req = "R6";
    wr(2'd3, 32'h2);
    cyc(32'h1234_5678, 32'h0, 32'hDEAD_BEEF, 16'h0, 16'h0);
    cyc(32'h1234_5678, 32'hDEAD_BEEF, 32'h5EAD_BEEF, 16'h0, 16'h0);

    // R7: X lane vs upper half, lower half ignored
    cur_req = "R7";
    wr(2'd2, 32'hA5A5_1234);
    wr(2'd3, 32'h3);
    cyc(32'h1234_5678, 32'h0, 32'h0, 16'hA5A5, 16'h1234);
    cyc(32'h1234_5678, 32'h0, 32'h0, 16'hA5A5, 16'h0000);
    cyc(32'h1234_5678, 32'h0, 32'h0, 16'h1234, 16'h1234);

    // R8: Y lane vs lower half, upper half ignored
    cur_req = "R8";
    wr(2'd3, 32'h7);
    cyc(32'h1234_5678, 32'h0, 32'h0, 16'h0000, 16'h1234);
    cyc(32'h1234_5678, 32'h0, 32'h0, 16'hA5A5, 16'hA5A5);
    wr(2'd2, 32'hFFFF_1234);
    cyc(32'h1234_5678, 32'h0, 32'h0, 16'h0, 16'h1234);

    // R9: no pulse without valid; back-to-back pulses
    cur_req = "R9";
    wr(2'd3, 32'h0);
    vld = 1'b0; ca = 32'h1234_5678; tick(); tick();
    check(brk === 1'b0, "R9", "no valid", {31'd0, brk}, 32'd0);
    vld = 1'b1; tick();
    check(brk === 1'b1, "R9", "pulse 1", {31'd0, brk}, 32'd1);
    tick();
    check(brk === 1'b1, "R9", "pulse 2", {31'd0, brk}, 32'd1);
    vld = 1'b0; tick();
    check(brk === 1'b0, "R9", "pulse end", {31'd0, brk}, 32'd0);

    // R10: write in same cycle as bus cycle uses old value
    cur_req = "R10";
    we = 1'b1; ra = 2'd0; wd = 32'h8000_0000;
    vld = 1'b1; ca = 32'h8000_0000;
    tick();
    check(brk === 1'b0, "R10", "old bar used", {31'd0, brk}, 32'd0);
    we = 1'b0;
    tick();
    check(brk === 1'b1, "R10", "new bar used", {31'd0, brk}, 32'd1);
    vld = 1'b0; tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule